// File: doc/BRIEF.md
# Address-Range Cache Maintenance Engine

This block carries out cache maintenance over a span of physical addresses in a shared last-level cache. Software programs a first address and an exclusive limit address. It then writes a control word that picks one of three per-line operations and sets a launch bit. The engine visits every 64-byte line that overlaps the span, lowest address first. For each line it presents one request on a valid/ready maintenance port and waits for the cache to take it before moving on.

The launch bit also serves as the busy flag. It reads back as 1 for as long as the walk is running, and the hardware clears it once the final line has been accepted. Software only needs to poll one bit to learn that the operation is complete. While a walk is running the engine accepts no reprogramming, so the span and the operation cannot change partway through.

Top module: `range_maint_engine`

## Requirements
- R1: After reset, the address, limit and control registers all read 0, and no maintenance request is presented.
- R2: Register offsets are: first address at 0x00, limit address at 0x08, control at 0x10, each 64 bits wide. Only bits 39:0 of the two address registers are stored. Bits 63:40 are dropped on write and read back as 0.
- R3: In the control register, bit 0 is the launch bit and bits 2:1 are the operation code. Writing 1 to bit 0 starts a walk. The launch bit reads 1 until the walk ends, and the operation code reads back as written.
- R4: Lines are visited in ascending order in steps of 64 bytes. The first line is the first address with bits 5:0 cleared. The last line visited is the highest line below the exclusive limit.
- R5: Each request carries the line address and the operation code on the op output: 0 is clean and invalidate, 1 is invalidate without writeback, 2 is clean while keeping the line valid.
- R6: While a request is valid and not yet accepted, it stays valid and its address and op do not change.
- R7: The launch bit stays 1 until the last line is accepted. It reads 0 from the second clock edge after that acceptance, and no further request is presented.
- R8: If the limit is not above the first address, no request is issued. The launch bit reads 1 for exactly one cycle and is clear after the following edge.
- R9: Operation code 3 is reserved. Launching with it issues no request and completes in the same way as R8.
- R10: While the launch bit is 1, writes to the address, limit and control registers have no effect.
- R11: Writing the control register with bit 0 at 0 updates the operation code but starts no walk.
- R12: Offsets other than 0x00, 0x08 and 0x10 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_ofs | input | 10 | Register byte offset within the window |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Read data for the register at reg_ofs (combinational) |
| mnt_valid | output | 1 | Maintenance request valid |
| mnt_ready | input | 1 | Cache accepts the request |
| mnt_addr | output | 40 | Line address of the request |
| mnt_op | output | 2 | Operation code of the request |

## Verification
The assertions assume the cache side obeys a plain valid/ready contract. They also assume that software touches the control register only through its defined fields, and that resets are synchronous. Nothing else is assumed about how often or when `mnt_ready` rises. To keep within that contract, the bench's cache model changes `mnt_ready` just after a clock edge, using a fixed pattern chosen per test: always ready, every second cycle, every third cycle, or held low. Register writes are made one at a time, each away from the clock edge. Busy-time writes are issued only while the model is holding `mnt_ready` low, so the frozen state can be read back before any line completes.

// File: rtl/rme_pkg.sv
package rme_pkg;

  // Line operation codes; the encoding is software-visible.
  typedef enum logic [1:0] {
    MNT_CLEAN_INV    = 2'd0,
    MNT_INV_ONLY     = 2'd1,
    MNT_CLEAN_SHARED = 2'd2,
    MNT_RESERVED     = 2'd3
  } mnt_op_e;

  typedef enum logic [1:0] {
    WLK_IDLE   = 2'd0,
    WLK_ISSUE  = 2'd1,
    WLK_FINISH = 2'd2
  } walk_state_e;

  localparam int unsigned OFS_FIRST    = 'h00;
  localparam int unsigned OFS_LIMIT    = 'h08;
  localparam int unsigned OFS_CTRL     = 'h10;
  localparam int unsigned WINDOW_BYTES = 'h278;
  localparam int unsigned REG_OFS_W    = $clog2(WINDOW_BYTES);

endpackage

// File: rtl/rme_regs.sv
module rme_regs
  import rme_pkg::*;
#(
  parameter int unsigned ADDR_W = 40,
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_OFS_W-1:0] ofs,
  input  logic [DATA_W-1:0] wdata,
  input  logic              walk_done,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] first_q,
  output logic [ADDR_W-1:0] limit_q,
  output logic [1:0]        mode_q,
  output logic              go_q,
  output logic              launch
);

  logic wr_open, sel_first, sel_limit, sel_ctrl;
  logic unused_wdata_hi;

  assign sel_first = (ofs == REG_OFS_W'(OFS_FIRST));
  assign sel_limit = (ofs == REG_OFS_W'(OFS_LIMIT));
  assign sel_ctrl  = (ofs == REG_OFS_W'(OFS_CTRL));
  // Programming is locked out for the whole walk.
  assign wr_open   = wr_en && !go_q;
  assign launch    = wr_open && sel_ctrl && wdata[0];
  assign unused_wdata_hi = ^wdata[DATA_W-1:ADDR_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_q <= '0;
      limit_q <= '0;
      mode_q  <= '0;
      go_q    <= 1'b0;
    end else if (wr_open) begin
      if (sel_first) first_q <= wdata[ADDR_W-1:0];
      if (sel_limit) limit_q <= wdata[ADDR_W-1:0];
      if (sel_ctrl) begin
        mode_q <= wdata[2:1];
        go_q   <= wdata[0];
      end
    end else if (walk_done) begin
      go_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel_first)      rdata[ADDR_W-1:0] = first_q;
    else if (sel_limit) rdata[ADDR_W-1:0] = limit_q;
    else if (sel_ctrl)  rdata[2:0]        = {mode_q, go_q};
  end

endmodule

// File: rtl/rme_walker.sv
module rme_walker
  import rme_pkg::*;
#(
  parameter int unsigned ADDR_W     = 40,
  parameter int unsigned LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [1:0]        mode_in,
  input  logic [ADDR_W-1:0] first_addr,
  input  logic [ADDR_W-1:0] limit_addr,
  input  logic              mnt_ready,
  output logic              mnt_valid,
  output logic [ADDR_W-1:0] mnt_addr,
  output logic [1:0]        mnt_op,
  output logic              walk_done,
  output logic              launch_skip
);

  localparam int unsigned LINE_SHIFT = $clog2(LINE_BYTES);

  // Round an address down to the start of its line.
  function automatic logic [ADDR_W-1:0] line_floor(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:LINE_SHIFT], LINE_SHIFT'(0)};
  endfunction

  // Following line address, one bit wider so the top of the space cannot wrap.
  function automatic logic [ADDR_W:0] line_step(input logic [ADDR_W-1:0] a);
    return {1'b0, a} + (ADDR_W+1)'(LINE_BYTES);
  endfunction

  function automatic logic span_empty(input logic [ADDR_W-1:0] lo,
                                      input logic [ADDR_W-1:0] hi);
    return hi <= lo;
  endfunction

  walk_state_e      state_q;
  logic [ADDR_W-1:0] cur_q;
  logic [1:0]        op_q;
  logic              line_accept;
  logic [ADDR_W:0]   nxt;

  assign launch_skip = span_empty(first_addr, limit_addr) || (mode_in == MNT_RESERVED);
  assign mnt_valid   = (state_q == WLK_ISSUE);
  assign mnt_addr    = cur_q;
  assign mnt_op      = op_q;
  assign line_accept = mnt_valid && mnt_ready;
  assign walk_done   = (state_q == WLK_FINISH);
  assign nxt         = line_step(cur_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WLK_IDLE;
      cur_q   <= '0;
      op_q    <= '0;
    end else begin
      unique case (state_q)
        WLK_IDLE: if (launch) begin
          cur_q   <= line_floor(first_addr);
          op_q    <= mode_in;
          state_q <= launch_skip ? WLK_FINISH : WLK_ISSUE;
        end
        WLK_ISSUE: if (line_accept) begin
          if (nxt >= {1'b0, limit_addr}) state_q <= WLK_FINISH;
          else                            cur_q   <= nxt[ADDR_W-1:0];
        end
        WLK_FINISH: state_q <= WLK_IDLE;
        default:    state_q <= WLK_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/range_maint_engine.sv
module range_maint_engine
  import rme_pkg::*;
#(
  parameter int unsigned ADDR_W     = 40,
  parameter int unsigned DATA_W     = 64,
  parameter int unsigned LINE_BYTES = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr_en,
  input  logic [REG_OFS_W-1:0] reg_ofs,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic                 mnt_valid,
  input  logic                 mnt_ready,
  output logic [ADDR_W-1:0]    mnt_addr,
  output logic [1:0]           mnt_op
);

  // Named internal events, also used by the bound checker.
  logic [ADDR_W-1:0] first_q, limit_q;
  logic [1:0]        mode_q;
  logic              go_q, launch, launch_skip, walk_done;

  rme_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr_en),
    .ofs       (reg_ofs),
    .wdata     (reg_wdata),
    .walk_done (walk_done),
    .rdata     (reg_rdata),
    .first_q   (first_q),
    .limit_q   (limit_q),
    .mode_q    (mode_q),
    .go_q      (go_q),
    .launch    (launch)
  );

  rme_walker #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_walker (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch      (launch),
    .mode_in     (reg_wdata[2:1]),
    .first_addr  (first_q),
    .limit_addr  (limit_q),
    .mnt_ready   (mnt_ready),
    .mnt_valid   (mnt_valid),
    .mnt_addr    (mnt_addr),
    .mnt_op      (mnt_op),
    .walk_done   (walk_done),
    .launch_skip (launch_skip)
  );

endmodule

// File: rtl/rme_checker.sv
module rme_checker #(
  parameter int unsigned ADDR_W     = 40,
  parameter int unsigned LINE_BYTES = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic              launch,
  input logic              launch_skip,
  input logic              go_q,
  input logic [1:0]        mode_q,
  input logic [ADDR_W-1:0] first_q,
  input logic [ADDR_W-1:0] limit_q,
  input logic              mnt_valid,
  input logic              mnt_ready,
  input logic [ADDR_W-1:0] mnt_addr,
  input logic [1:0]        mnt_op
);

  logic              acc;
  logic              prev_ok;
  logic [ADDR_W-1:0] prev_addr;

  assign acc = mnt_valid && mnt_ready;

  always_ff @(posedge clk) begin
    if (!rst_n || !go_q) begin
      prev_ok   <= 1'b0;
      prev_addr <= '0;
    end else if (acc) begin
      prev_ok   <= 1'b1;
      prev_addr <= mnt_addr;
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> !mnt_valid);

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && prev_ok |-> mnt_addr == prev_addr + ADDR_W'(LINE_BYTES));

  p_in_span_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mnt_valid |-> ({1'b0, mnt_addr} < {1'b0, limit_q}) &&
                  ({1'b0, mnt_addr} + (ADDR_W+1)'(LINE_BYTES) > {1'b0, first_q}));

  p_op_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mnt_valid |-> (mnt_op == mode_q) && (mnt_op != 2'd3));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mnt_valid && !mnt_ready |=> mnt_valid && $stable(mnt_addr) && $stable(mnt_op));

  p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mnt_valid |-> go_q);

  p_skip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    launch && launch_skip |=> go_q && !mnt_valid ##1 !go_q);

  p_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    go_q && reg_wr_en |=> $stable(first_q) && $stable(limit_q) && $stable(mode_q));

endmodule

bind range_maint_engine rme_checker #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_rme_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr_en   (reg_wr_en),
  .launch      (launch),
  .launch_skip (launch_skip),
  .go_q        (go_q),
  .mode_q      (mode_q),
  .first_q     (first_q),
  .limit_q     (limit_q),
  .mnt_valid   (mnt_valid),
  .mnt_ready   (mnt_ready),
  .mnt_addr    (mnt_addr),
  .mnt_op      (mnt_op)
);

// File: tb/range_maint_engine_bench.sv
`timescale 1ns/1ps
module range_maint_engine_bench;

  localparam real CLK_NS = 8.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [9:0]  reg_ofs = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        mnt_valid;
  logic        mnt_ready = 1'b0;
  logic [39:0] mnt_addr;
  logic [1:0]  mnt_op;

  range_maint_engine u_range_maint_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_ofs(reg_ofs),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mnt_valid(mnt_valid),
    .mnt_ready(mnt_ready), .mnt_addr(mnt_addr), .mnt_op(mnt_op)
  );

  always #(CLK_NS/2) clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  int ncyc  = 0;
  int ready_mode = 0;
  int rcnt = 0;

  // Accepted-line log filled by the cache model.
  logic [39:0] acc_addr [256];
  logic [1:0]  acc_op   [256];
  int          acc_n = 0;
  int          last_acc_cyc = 0;
  logic        hold_pend = 1'b0;
  logic [39:0] hold_addr;
  logic [1:0]  hold_op;

  // {first[39:0], limit[39:0], op[1:0], ready pattern[1:0]}
  localparam logic [83:0] VEC [8] = '{
    {40'h00_0000_1000, 40'h00_0000_1100, 2'd0, 2'd0},
    {40'h00_0000_1010, 40'h00_0000_1050, 2'd1, 2'd1},
    {40'h00_0000_2000, 40'h00_0000_2001, 2'd2, 2'd2},
    {40'h00_0000_3FC0, 40'h00_0000_4040, 2'd0, 2'd1},
    {40'h00_0000_5000, 40'h00_0000_5000, 2'd0, 2'd0},
    {40'h00_0000_6000, 40'h00_0000_5000, 2'd1, 2'd0},
    {40'h00_0000_7000, 40'h00_0000_7100, 2'd3, 2'd0},
    {40'hFF_FFFF_FFC0, 40'hFF_FFFF_FFFF, 2'd2, 2'd2}
  };

  always @(posedge clk) ncyc <= ncyc + 1;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  task automatic wr(input logic [9:0] o, input logic [63:0] d);
    @(negedge clk);
    reg_ofs = o; reg_wdata = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [9:0] o, output logic [63:0] v);
    reg_ofs = o;
    #1;
    v = reg_rdata;
  endtask

  // Poll the launch bit; returns negedges waited and the cycle it read 0.
  task automatic poll(output int waited, output int zero_cyc);
    logic [63:0] v;
    waited = 0;
    rd(10'h10, v);
    while (v[0] && waited < 400) begin
      @(negedge clk);
      rd(10'h10, v);
      waited++;
    end
    zero_cyc = ncyc;
    if (v[0]) begin
      n_chk++; n_err++;
      $display("FAIL R7 launch bit never cleared actual=1 expected=0");
    end
  endtask

  // Cache model: ready changes just after each edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      rcnt++;
      case (ready_mode)
        0: mnt_ready = 1'b1;
        1: mnt_ready = rcnt[0];
        2: mnt_ready = (rcnt % 3 == 0);
        default: mnt_ready = 1'b0;
      endcase
    end
  end

  // Monitor at negedge: log accepted lines and check request holding (R6).
  initial begin
    forever begin
      @(negedge clk);
      if (hold_pend) begin
        chk("R6 valid held", {63'b0, mnt_valid}, 64'd1);
        chk("R6 addr held", {24'b0, mnt_addr}, {24'b0, hold_addr});
        chk("R6 op held", {62'b0, mnt_op}, {62'b0, hold_op});
      end
      hold_pend = mnt_valid && !mnt_ready;
      hold_addr = mnt_addr;
      hold_op   = mnt_op;
      if (mnt_valid && mnt_ready && acc_n < 256) begin
        acc_addr[acc_n] = mnt_addr;
        acc_op[acc_n]   = mnt_op;
        acc_n++;
        last_acc_cyc = ncyc;
      end
    end
  end

  initial begin
    #(CLK_NS * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [63:0] v;
    logic [39:0] s, e, first;
    logic [40:0] span;
    logic [1:0]  m;
    int base, expn, waited, zcyc;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(10'h00, v); chk("R1 first reg after reset", v, 64'd0);
    rd(10'h08, v); chk("R1 limit reg after reset", v, 64'd0);
    rd(10'h10, v); chk("R1 ctrl reg after reset", v, 64'd0);
    chk("R1 no request after reset", {63'b0, mnt_valid}, 64'd0);

    // Vector walk
    for (int i = 0; i < 8; i++) begin
      s = VEC[i][83:44]; e = VEC[i][43:4]; m = VEC[i][3:2];
      ready_mode = int'(VEC[i][1:0]);
      wr(10'h00, {24'hA5C3E1, s});
      rd(10'h00, v); chk("R2 first addr upper bits dropped", v, {24'b0, s});
      wr(10'h08, {24'h5A3C1E, e});
      rd(10'h08, v); chk("R2 limit addr upper bits dropped", v, {24'b0, e});
      first = (s >> 6) << 6;
      if (m == 2'd3 || e <= s) expn = 0;
      else begin
        span = {1'b0, e} - {1'b0, first};
        expn = int'((span + 41'd63) >> 6);
      end
      base = acc_n;
      wr(10'h10, {61'b0, m, 1'b1});
      rd(10'h10, v);
      chk("R3 launch bit reads 1 after launch", {63'b0, v[0]}, 64'd1);
      chk("R3 op code reads back", {62'b0, v[2:1]}, {62'b0, m});
      poll(waited, zcyc);
      chk("R4 line count", 64'(acc_n - base), 64'(expn));
      if (expn == 0) begin
        if (m == 2'd3) chk("R9 reserved op completes in one cycle", 64'(waited), 64'd1);
        else           chk("R8 empty span completes in one cycle", 64'(waited), 64'd1);
      end else begin
        chk("R7 launch bit clears two edges after last accept", 64'(zcyc - last_acc_cyc), 64'd2);
      end
      for (int j = 0; j < expn; j++) begin
        chk("R4 line address", {24'b0, acc_addr[base+j]}, {24'b0, first + 40'(64 * j)});
        chk("R5 line op", {62'b0, acc_op[base+j]}, {62'b0, m});
      end
      repeat (2) @(negedge clk);
      chk("R7 no request after completion", {63'b0, mnt_valid}, 64'd0);
    end

    // R11: control write without launch bit
    ready_mode = 0;
    wr(10'h10, 64'h6);
    rd(10'h10, v); chk("R11 op code updated without launch", v, 64'h6);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R11 no request without launch", {63'b0, mnt_valid}, 64'd0);
    end

    // R12: unmapped offset
    wr(10'h00, 64'h1234_0000);
    wr(10'h18, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(10'h18, v); chk("R12 unmapped offset reads 0", v, 64'd0);
    rd(10'h00, v); chk("R12 first addr untouched by unmapped write", v, 64'h1234_0000);

    // R10: writes ignored while busy (cache stalled)
    ready_mode = 3;
    wr(10'h00, 64'h1_0000);
    wr(10'h08, 64'h1_0400);
    base = acc_n;
    wr(10'h10, 64'h3);
    wr(10'h00, 64'hAAAA);
    wr(10'h08, 64'h0);
    wr(10'h10, 64'h0);
    rd(10'h00, v); chk("R10 first addr frozen while busy", v, 64'h1_0000);
    rd(10'h08, v); chk("R10 limit addr frozen while busy", v, 64'h1_0400);
    rd(10'h10, v); chk("R10 ctrl frozen while busy", v, 64'h3);
    chk("R6 stalled request still valid", {63'b0, mnt_valid}, 64'd1);
    chk("R4 stalled request is first line", {24'b0, mnt_addr}, 64'h1_0000);
    ready_mode = 0;
    poll(waited, zcyc);
    chk("R4 line count after busy writes", 64'(acc_n - base), 64'd16);
    chk("R5 op after busy writes", {62'b0, acc_op[base+15]}, 64'd1);
    chk("R4 last line below limit", {24'b0, acc_addr[base+15]}, 64'h1_03C0);

    summary();
    $finish;
  end

endmodule